// File: doc/BRIEF.md
# Quadrature Position Decoder with Event Interrupts

This block turns the two phase signals of an incremental encoder, plus its once-per-turn marker, into a position count, a direction flag and a speed measure. The speed measure is the number of edges counted in each period of a reloading timer. Four event sources feed a sticky status vector. Software selects which of them drive the single interrupt line and clears them by writing ones.

Configuration is presented as plain level inputs:
- which edges count;
- whether the phases are exchanged;
- whether the marker rezeroes the count;
- the largest position value.

A one-cycle write strobe presets the position. The marker is tied to the rezero mode. With that mode off, the marker is ignored entirely and can never raise its status bit, and the count wraps inside the range from zero to the programmed maximum.

Each phase and marker input passes through two synchronizing flops and a previous-sample register. A change at a pin therefore shows in the position on the third rising clock edge after the pin changes.

Top module: `qenc_unit`

## Requirements
- R1: With both-phase capture on, every synchronized edge of A and of B moves the position by one. With (A,B) the sequence 00, 10, 11, 01, 00 counts up, and the reverse sequence counts down.
- R2: With both-phase capture off, only edges of A are counted, in the direction given by R1, and edges of B leave the position unchanged.
- R3: With the swap input high, A and B are exchanged before decoding, so the pin sequence that counts up in R1 counts down.
- R4: Counting up from the programmed maximum gives 0, and counting down from 0 gives the maximum.
- R5: With the rezero mode low, a marker pulse leaves the position unchanged and status bit 0 stays 0.
- R6: With the rezero mode high, a rising marker edge sets the position to 0 and sets status bit 0 (marker seen).
- R7: A position write strobe loads the written value, and it takes priority over the marker and over counting in the same cycle.
- R8: A sample in which A and B both change sets status bit 3 (phase fault) and leaves the position unchanged.
- R9: The direction output resets to 1 (up) and follows the last counted edge, with 0 meaning down. Status bit 2 (reversal) sets on a counted edge whose direction differs from the previous counted edge, and never on the first counted edge after reset.
- R10: While the speed timer is enabled, it runs for load+1 cycles per period. At the end of each period it latches the number of edges counted in that period on the speed output, and it sets status bit 1 (period end).
- R11: Status bits set on their event whether or not they are enabled, and stay set until a one is written to the same bit of the clear input. An event wins over a clear in the same cycle.
- R12: The masked status is the raw status ANDed bit by bit with the enable input, and the interrupt output is high when any masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pha_in | input | 1 | Encoder phase A pin |
| phb_in | input | 1 | Encoder phase B pin |
| mark_in | input | 1 | Once-per-turn marker pin |
| cfg_both | input | 1 | 1: count edges of A and B; 0: count edges of A only |
| cfg_swap | input | 1 | Exchange A and B before decoding |
| cfg_rezero | input | 1 | Marker rezeroes the position and may raise status bit 0 |
| cfg_max | input | POS_W | Largest position value |
| pos_wr | input | 1 | Position write strobe |
| pos_wdata | input | POS_W | Position write value |
| spd_en | input | 1 | Speed timer run enable |
| spd_load | input | TMR_W | Speed timer reload value |
| ev_en | input | 4 | Interrupt enable per status bit |
| ev_clr | input | 4 | Write-one-to-clear strobe per status bit |
| pos_out | output | POS_W | Position count |
| dir_out | output | 1 | Direction of the last counted edge (1 = up) |
| spd_out | output | TMR_W | Edge count of the last completed period |
| ev_raw | output | 4 | Raw status: 0 marker, 1 period end, 2 reversal, 3 fault |
| ev_masked | output | 4 | Raw status AND enable |
| irq | output | 1 | OR of the masked status |

## Verification
The counting function is driven with forward and backward Gray sequences under full capture, A-only capture and swapped phases, so that a decoder that reads the phase relation wrongly, counts the wrong edges or ignores the swap gives a different final position. The boundary is approached from both sides with a small maximum, which separates a wrapping counter from a saturating or free-running one. Marker pulses are applied with the rezero mode both off and on, and a simultaneous change of both phases is applied, to tell ignored events from acted-on events. A steady edge train at a fixed spacing gives an exact per-period edge count.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int EV_N    = 4;
  localparam int EV_MARK = 0;
  localparam int EV_TMR  = 1;
  localparam int EV_REV  = 2;
  localparam int EV_ERR  = 3;

  // Direction of a single-phase change: 1 = up.
  function automatic logic step_is_up(input logic a_moved, input logic a_now,
                                      input logic b_now);
    if (a_moved) return (a_now != b_now);
    return (a_now == b_now);
  endfunction

  // Next position after one counted step, wrapping inside [0:lim].
  function automatic logic [63:0] wrap_step(input logic [63:0] cur,
                                            input logic up,
                                            input logic [63:0] lim);
    if (up) return (cur >= lim) ? 64'd0 : cur + 64'd1;
    return (cur == 64'd0) ? lim : cur - 64'd1;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] sync_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= pin_i[g];
        st2 <= st1;
      end
    end
    assign sync_o[g] = st2;
  end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_s,
  input  logic b_s,
  input  logic mark_s,
  input  logic cfg_both,
  input  logic cfg_swap,
  input  logic cfg_rezero,
  output logic step_up,
  output logic step_dn,
  output logic fault_evt,
  output logic mark_hit,
  output logic rev_evt,
  output logic dir_q
);

  logic a_d, b_d, a_p, b_p, mark_p, seen_q;
  logic a_moved, b_moved, one_moved, counted, up;

  assign a_d = cfg_swap ? b_s : a_s;
  assign b_d = cfg_swap ? a_s : b_s;

  assign a_moved   = a_d ^ a_p;
  assign b_moved   = b_d ^ b_p;
  assign one_moved = a_moved ^ b_moved;
  assign fault_evt = a_moved & b_moved;
  assign up        = step_is_up(a_moved, a_d, b_d);
  assign counted   = one_moved & (cfg_both | a_moved);
  assign step_up   = counted & up;
  assign step_dn   = counted & ~up;
  assign rev_evt   = counted & seen_q & (up != dir_q);
  assign mark_hit  = cfg_rezero & mark_s & ~mark_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p    <= 1'b0;
      b_p    <= 1'b0;
      mark_p <= 1'b0;
      seen_q <= 1'b0;
      dir_q  <= 1'b1;
    end else begin
      a_p    <= a_d;
      b_p    <= b_d;
      mark_p <= mark_s;
      if (counted) begin
        seen_q <= 1'b1;
        dir_q  <= up;
      end
    end
  end

  AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> !dir_q) else $error("down step left direction up"); // R9

endmodule

// File: rtl/qenc_position.sv
module qenc_position
  import qenc_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             mark_hit,
  input  logic             pos_wr,
  input  logic [POS_W-1:0] pos_wdata,
  input  logic [POS_W-1:0] cfg_max,
  output logic [POS_W-1:0] pos_q
);

  logic [63:0] nxt_wide;
  logic [POS_W-1:0] pos_nxt;

  assign nxt_wide = wrap_step(64'(pos_q), step_up, 64'(cfg_max));

  always_comb begin
    pos_nxt = pos_q;
    if (pos_wr)                pos_nxt = pos_wdata;
    else if (mark_hit)         pos_nxt = '0;
    else if (step_up | step_dn) pos_nxt = nxt_wide[POS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nxt;
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !pos_wr && !mark_hit && pos_q < cfg_max)
      |=> pos_q == $past(pos_q) + 1'b1) else $error("up step miscounted"); // R1
  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !pos_wr && !mark_hit && pos_q == cfg_max)
      |=> pos_q == '0) else $error("no wrap at max"); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pos_wr |=> pos_q == $past(pos_wdata)) else $error("write lost"); // R7

endmodule

// File: rtl/qenc_speed.sv
module qenc_speed #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_en,
  input  logic [TMR_W-1:0] spd_load,
  input  logic             edge_i,
  output logic             period_end,
  output logic [TMR_W-1:0] spd_q
);

  logic [TMR_W-1:0] tmr_q, acc_q;

  assign period_end = spd_en & (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      acc_q <= '0;
      spd_q <= '0;
    end else if (!spd_en) begin
      tmr_q <= spd_load;
      acc_q <= '0;
    end else if (period_end) begin
      tmr_q <= spd_load;
      acc_q <= '0;
      spd_q <= acc_q + TMR_W'(edge_i);
    end else begin
      tmr_q <= tmr_q - 1'b1;
      acc_q <= acc_q + TMR_W'(edge_i);
    end
  end

  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> tmr_q == $past(spd_load)) else $error("no reload"); // R10

endmodule

// File: rtl/qenc_events.sv
module qenc_events
  import qenc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev_hit,
  input  logic [EV_N-1:0] ev_en,
  input  logic [EV_N-1:0] ev_clr,
  output logic [EV_N-1:0] raw_q,
  output logic [EV_N-1:0] masked,
  output logic            irq
);

  for (genvar g = 0; g < EV_N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         raw_q[g] <= 1'b0;
      else if (ev_hit[g]) raw_q[g] <= 1'b1;
      else if (ev_clr[g]) raw_q[g] <= 1'b0;
    end

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[g] && !ev_clr[g]) |=> raw_q[g]) else $error("status dropped"); // R11
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_hit[g] |=> raw_q[g]) else $error("event lost"); // R11
  end

  assign masked = raw_q & ev_en;
  assign irq    = |masked;

endmodule

// File: rtl/qenc_unit.sv
module qenc_unit
  import qenc_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pha_in,
  input  logic             phb_in,
  input  logic             mark_in,
  input  logic             cfg_both,
  input  logic             cfg_swap,
  input  logic             cfg_rezero,
  input  logic [POS_W-1:0] cfg_max,
  input  logic             pos_wr,
  input  logic [POS_W-1:0] pos_wdata,
  input  logic             spd_en,
  input  logic [TMR_W-1:0] spd_load,
  input  logic [3:0]       ev_en,
  input  logic [3:0]       ev_clr,
  output logic [POS_W-1:0] pos_out,
  output logic             dir_out,
  output logic [TMR_W-1:0] spd_out,
  output logic [3:0]       ev_raw,
  output logic [3:0]       ev_masked,
  output logic             irq
);

  localparam int LANES = 3;

  logic [LANES-1:0] pins_s;
  logic step_up, step_dn, fault_evt, mark_hit, rev_evt, period_end;
  logic [EV_N-1:0] ev_hit;

  qenc_sync #(.LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({mark_in, phb_in, pha_in}), .sync_o(pins_s)
  );

  qenc_decode u_decode (
    .clk(clk), .rst_n(rst_n),
    .a_s(pins_s[0]), .b_s(pins_s[1]), .mark_s(pins_s[2]),
    .cfg_both(cfg_both), .cfg_swap(cfg_swap), .cfg_rezero(cfg_rezero),
    .step_up(step_up), .step_dn(step_dn), .fault_evt(fault_evt),
    .mark_hit(mark_hit), .rev_evt(rev_evt), .dir_q(dir_out)
  );

  qenc_position #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n),
    .step_up(step_up), .step_dn(step_dn), .mark_hit(mark_hit),
    .pos_wr(pos_wr), .pos_wdata(pos_wdata), .cfg_max(cfg_max),
    .pos_q(pos_out)
  );

  qenc_speed #(.TMR_W(TMR_W)) u_speed (
    .clk(clk), .rst_n(rst_n),
    .spd_en(spd_en), .spd_load(spd_load), .edge_i(step_up | step_dn),
    .period_end(period_end), .spd_q(spd_out)
  );

  always_comb begin
    ev_hit          = '0;
    ev_hit[EV_MARK] = mark_hit;
    ev_hit[EV_TMR]  = period_end;
    ev_hit[EV_REV]  = rev_evt;
    ev_hit[EV_ERR]  = fault_evt;
  end

  qenc_events u_events (
    .clk(clk), .rst_n(rst_n),
    .ev_hit(ev_hit), .ev_en(ev_en), .ev_clr(ev_clr),
    .raw_q(ev_raw), .masked(ev_masked), .irq(irq)
  );

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && !pos_wr && !mark_hit) |=> $stable(pos_out)) else $error("fault moved position"); // R8
  AST_MARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_hit && !pos_wr) |=> pos_out == '0) else $error("marker did not rezero"); // R6
  AST_MARK_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_raw[EV_MARK]) |-> $past(cfg_rezero)) else $error("marker status without mode"); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_raw & ev_en) != '0) else $error("irq without enabled status"); // R12

endmodule

// File: tb/qenc_unit_bench.sv
module qenc_unit_bench;

  localparam int PW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pha = 1'b0, phb = 1'b0, mark = 1'b0;
  logic cfg_both = 1'b1, cfg_swap = 1'b0, cfg_rezero = 1'b0;
  logic [PW-1:0] cfg_max = 16'd255;
  logic pos_wr = 1'b0;
  logic [PW-1:0] pos_wdata = '0;
  logic spd_en = 1'b0;
  logic [TW-1:0] spd_load = '0;
  logic [3:0] ev_en = '0, ev_clr = '0;
  logic [PW-1:0] pos_out;
  logic dir_out, irq;
  logic [TW-1:0] spd_out;
  logic [3:0] ev_raw, ev_masked;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qenc_unit #(.POS_W(PW), .TMR_W(TW)) u_qenc_unit (
    .clk(clk), .rst_n(rst_n), .pha_in(pha), .phb_in(phb), .mark_in(mark),
    .cfg_both(cfg_both), .cfg_swap(cfg_swap), .cfg_rezero(cfg_rezero),
    .cfg_max(cfg_max), .pos_wr(pos_wr), .pos_wdata(pos_wdata),
    .spd_en(spd_en), .spd_load(spd_load), .ev_en(ev_en), .ev_clr(ev_clr),
    .pos_out(pos_out), .dir_out(dir_out), .spd_out(spd_out),
    .ev_raw(ev_raw), .ev_masked(ev_masked), .irq(irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One Gray step on the pins, then wait past the 3-edge latency.
  task automatic move(input bit up, input int gap);
    @(negedge clk);
    case ({pha, phb})
      2'b00: {pha, phb} = up ? 2'b10 : 2'b01;
      2'b10: {pha, phb} = up ? 2'b11 : 2'b00;
      2'b11: {pha, phb} = up ? 2'b01 : 2'b10;
      default: {pha, phb} = up ? 2'b00 : 2'b11;
    endcase
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic preset(input logic [PW-1:0] v);
    @(negedge clk);
    pos_wr = 1'b1; pos_wdata = v;
    @(negedge clk);
    pos_wr = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    ev_clr = 4'hF;
    @(negedge clk);
    ev_clr = 4'h0;
  endtask

  task automatic pulse_mark();
    @(negedge clk); mark = 1'b1;
    repeat (3) @(negedge clk); mark = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 reset dir", dir_out, 1);
    check("R1 reset pos", pos_out, 0);
    check("R11 reset raw", ev_raw, 0);
    check("R12 reset irq", irq, 0);
  endtask

  task automatic t_count4x();
    for (int i = 0; i < 8; i++) move(1'b1, 5);
    check("R1 up x8", pos_out, 8);
    check("R9 no reversal yet", ev_raw[2], 0);
    check("R9 dir up", dir_out, 1);
    for (int i = 0; i < 3; i++) move(1'b0, 5);
    check("R1 down x3", pos_out, 5);
    check("R9 dir down", dir_out, 0);
    check("R9 reversal set", ev_raw[2], 1);
  endtask

  task automatic t_mask();
    check("R12 disabled no irq", irq, 0);
    @(negedge clk); ev_en = 4'b0100;
    @(negedge clk);
    check("R12 irq on enable", irq, 1);
    check("R12 masked", ev_masked, 4'b0100);
    @(negedge clk); ev_clr = 4'b0100;
    @(negedge clk); ev_clr = 4'b0000;
    check("R11 w1c clears", ev_raw[2], 0);
    check("R12 irq drops", irq, 0);
    ev_en = 4'b0000;
  endtask

  task automatic t_wrap();
    cfg_max = 16'd10;
    preset(16'd10);
    check("R7 preset", pos_out, 10);
    move(1'b1, 5);
    check("R4 wrap up", pos_out, 0);
    move(1'b0, 5);
    check("R4 wrap down", pos_out, 10);
  endtask

  task automatic t_mark_off();
    cfg_rezero = 1'b0;
    pulse_mark();
    check("R5 pos kept", pos_out, 10);
    check("R5 no status", ev_raw[0], 0);
  endtask

  task automatic t_mark_on();
    cfg_rezero = 1'b1;
    pulse_mark();
    check("R6 pos zero", pos_out, 0);
    check("R6 status", ev_raw[0], 1);
    cfg_rezero = 1'b0;
    clear_all();
  endtask

  task automatic t_fault();
    @(negedge clk); {pha, phb} = ~{pha, phb};
    repeat (5) @(negedge clk);
    check("R8 fault bit", ev_raw[3], 1);
    check("R8 pos kept", pos_out, 0);
    clear_all();
  endtask

  task automatic t_swap();
    cfg_max = 16'd255;
    if (pha != phb) move(1'b1, 5);
    preset(16'd5);
    @(negedge clk); cfg_swap = 1'b1;
    repeat (3) @(negedge clk);
    move(1'b1, 5);
    move(1'b1, 5);
    check("R3 swapped counts down", pos_out, 3);
    @(negedge clk); cfg_swap = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_aonly();
    preset(16'd0);
    cfg_both = 1'b0;
    for (int i = 0; i < 4; i++) move(1'b1, 5);
    check("R2 A edges only", pos_out, 2);
    cfg_both = 1'b1;
  endtask

  task automatic t_speed();
    clear_all();
    @(negedge clk); spd_load = 16'd99; spd_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      move(1'b1, 5);
      if (i == 49) begin
        check("R10 edges per period", spd_out, 20);
        check("R10 period status", ev_raw[1], 1);
      end
    end
    spd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count4x();
    t_mask();
    t_wrap();
    t_mark_off();
    t_mark_on();
    t_fault();
    t_swap();
    t_aonly();
    t_speed();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule